// File: doc/BRIEF.md
# Lazy Condition Flag Evaluator

This block turns a deferred flag record into the four arithmetic flags N, Z, V and C. A processor datapath that wants to skip flag work on every instruction saves only two words per flag-setting operation (the result and the source operand) and a class code naming the formula. When the flags are finally needed, the record is streamed into this unit. The unit rebuilds the missing operand from those two words (for an add, the other addend is result minus source; for a subtract, the minuend is result plus source) and from that derives carry/borrow and overflow. Byte and word compares are evaluated on the low 8 or 16 bits. The extended add and subtract forms account for the incoming extend bit.

Records enter on a valid/ready channel and leave one cycle later on a valid/ready channel. A record moves in when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output beat is held unchanged and no new record is taken. A sticky-zero qualifier supports multi-word arithmetic: the unit remembers the Z of the last accepted record, and when the qualifier is set, Z can only stay set or be cleared. A nonzero word anywhere in a chain therefore keeps Z clear. Class codes outside the defined set raise a one-cycle error pulse.

Top module: `ccf_lazy_eval`

## Requirements
- R1: For every class other than passthrough, Z is set when the evaluated result (low 8 bits for class 4, low 16 for class 5, else all W bits) is zero. Otherwise N equals that result's top bit. N and Z are never both set. Flags are packed in `out_flags` as bit 3 N, bit 2 Z, bit 1 V, bit 0 C.
- R2: Class 2 (add): C is set when the result is unsigned below the source. V is set when the rebuilt addend (result minus source) has the source's sign and the result's sign differs from it.
- R3: Class 3 (subtract): the minuend is rebuilt as result plus source. C is set when that minuend is unsigned below the source. V is set when the minuend's sign differs from both the result's and the source's sign.
- R4: Classes 4 and 5 (byte and word compare) apply the R3 rules to bits 7:0 and 15:0 only, with the sign taken at bit 7 or bit 15. Upper bits have no effect.
- R5: Class 6 (add with extend): C is set when the result is unsigned less than or equal to the source. V uses the rebuilt addend result minus source minus one, with the sign test of R2.
- R6: Class 7 (subtract with extend): the minuend is rebuilt as result plus source plus one. C is set when it is unsigned less than or equal to the source. V uses the sign test of R3 on that minuend.
- R7: Class 8 (shift): C is set exactly when the source word is nonzero, and V is clear. Class 1 (logic): V and C are clear. Both classes take N and Z per R1.
- R8: Class 0 (passthrough): `out_flags` equals bits 3:0 of the result word.
- R9: When `in_sticky` is high on a valid-class record, the output Z is the R1/R8 value ANDed with the Z of the previously accepted valid-class record.
- R10: Classes 9 to 15 give `out_flags` = 0 and raise `err_pulse` for exactly the cycle after acceptance, even while the output is stalled. Such a record leaves the remembered Z untouched.
- R11: An accepted record appears on `out_flags` with `out_valid` high one cycle later. While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_flags` holds.
- R12: After reset, `out_valid`, `out_flags` and `err_pulse` are 0, and the remembered Z is set, so a first sticky record behaves as non-sticky.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Record offered |
| in_ready | output | 1 | Record can be taken this cycle |
| in_cls | input | 4 | Formula class code |
| in_res | input | W | Saved result word |
| in_src | input | W | Saved source operand |
| in_sticky | input | 1 | Z may only be cleared (multi-word chain) |
| out_valid | output | 1 | Flag beat present |
| out_ready | input | 1 | Consumer takes the beat |
| out_flags | output | 4 | {N, Z, V, C} |
| err_pulse | output | 1 | One-cycle pulse after an undefined class is accepted |

## Verification
Two functions can fall in the same cycle: a stalled output beat and the arrival of the next record, which may carry the sticky qualifier or an undefined class. The bench stalls the consumer and then offers a sticky record with a nonzero result. It judges that the held flags do not move, that `in_ready` stays low, and that the remembered Z changes only when the record is actually taken. A later sticky zero-result record must then report Z clear. An undefined class accepted into an empty but stalled output must still pulse the error line for exactly one cycle.

// File: rtl/ccf_pkg.sv
package ccf_pkg;

  localparam int CLS_W = 4;

  typedef enum logic [CLS_W-1:0] {
    CC_PASS  = 4'd0,
    CC_LOGIC = 4'd1,
    CC_ADD   = 4'd2,
    CC_SUB   = 4'd3,
    CC_CMP8  = 4'd4,
    CC_CMP16 = 4'd5,
    CC_ADDX  = 4'd6,
    CC_SUBX  = 4'd7,
    CC_SHIFT = 4'd8
  } cc_class_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } ccf_t;

endpackage

// File: rtl/ccf_nz.sv
module ccf_nz #(
  parameter int WID = 32
) (
  input  logic [WID-1:0] val,
  output logic           z,
  output logic           n
);
  // Zero wins over negative: a zero word never reports N.
  assign z = (val == '0);
  assign n = !z && val[WID-1];
endmodule

// File: rtl/ccf_addchk.sv
module ccf_addchk #(
  parameter int WID = 32
) (
  input  logic [WID-1:0] res,
  input  logic [WID-1:0] src,
  input  logic           ext,
  output logic           c,
  output logic           v
);
  logic [WID-1:0] addend;

  // The missing addend is recovered from the stored sum and source.
  assign addend = res - src - WID'(ext);
  assign c = ext ? (res <= src) : (res < src);
  assign v = (src[WID-1] ^ res[WID-1]) & ~(addend[WID-1] ^ src[WID-1]);
endmodule

// File: rtl/ccf_subchk.sv
module ccf_subchk #(
  parameter int WID = 32
) (
  input  logic [WID-1:0] res,
  input  logic [WID-1:0] src,
  input  logic           ext,
  output logic           c,
  output logic           v
);
  logic [WID-1:0] minuend;

  // The minuend is recovered as difference plus subtrahend (plus extend).
  assign minuend = res + src + WID'(ext);
  assign c = ext ? (minuend <= src) : (minuend < src);
  assign v = (minuend[WID-1] ^ res[WID-1]) & (minuend[WID-1] ^ src[WID-1]);
endmodule

// File: rtl/ccf_formula.sv
module ccf_formula
  import ccf_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [CLS_W-1:0] cls,
  input  logic [W-1:0]     res,
  input  logic [W-1:0]     src,
  output ccf_t             flags,
  output logic             bad
);
  localparam int LANES = 2;   // byte and halfword compare lanes

  logic full_z, full_n;
  logic add_c, add_v, addx_c, addx_v;
  logic sub_c, sub_v, subx_c, subx_v;
  logic [LANES-1:0] ln_z, ln_n, ln_c, ln_v;

  ccf_nz #(.WID(W)) u_nz_full (.val(res), .z(full_z), .n(full_n));

  ccf_addchk #(.WID(W)) u_add  (.res(res), .src(src), .ext(1'b0), .c(add_c),  .v(add_v));
  ccf_addchk #(.WID(W)) u_addx (.res(res), .src(src), .ext(1'b1), .c(addx_c), .v(addx_v));
  ccf_subchk #(.WID(W)) u_sub  (.res(res), .src(src), .ext(1'b0), .c(sub_c),  .v(sub_v));
  ccf_subchk #(.WID(W)) u_subx (.res(res), .src(src), .ext(1'b1), .c(subx_c), .v(subx_v));

  // Narrow compare lanes: lane g works on the low (8 << g) bits.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int LW = 8 << g;
    ccf_nz #(.WID(LW)) u_nz (
      .val(res[LW-1:0]), .z(ln_z[g]), .n(ln_n[g])
    );
    ccf_subchk #(.WID(LW)) u_cmp (
      .res(res[LW-1:0]), .src(src[LW-1:0]), .ext(1'b0),
      .c(ln_c[g]), .v(ln_v[g])
    );
  end

  always_comb begin
    flags = '0;
    bad   = 1'b0;
    unique case (cc_class_e'(cls))
      CC_PASS:  flags = ccf_t'(res[3:0]);
      CC_LOGIC: flags = '{n: full_n, z: full_z, v: 1'b0, c: 1'b0};
      CC_ADD:   flags = '{n: full_n, z: full_z, v: add_v,  c: add_c};
      CC_SUB:   flags = '{n: full_n, z: full_z, v: sub_v,  c: sub_c};
      CC_CMP8:  flags = '{n: ln_n[0], z: ln_z[0], v: ln_v[0], c: ln_c[0]};
      CC_CMP16: flags = '{n: ln_n[1], z: ln_z[1], v: ln_v[1], c: ln_c[1]};
      CC_ADDX:  flags = '{n: full_n, z: full_z, v: addx_v, c: addx_c};
      CC_SUBX:  flags = '{n: full_n, z: full_z, v: subx_v, c: subx_c};
      CC_SHIFT: flags = '{n: full_n, z: full_z, v: 1'b0, c: (src != '0)};
      default:  bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/ccf_lazy_eval.sv
module ccf_lazy_eval
  import ccf_pkg::*;
#(
  parameter int W = 32    // at least 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [CLS_W-1:0] in_cls,
  input  logic [W-1:0]     in_res,
  input  logic [W-1:0]     in_src,
  input  logic             in_sticky,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [3:0]       out_flags,
  output logic             err_pulse
);
  localparam logic [CLS_W-1:0] LAST_CLS = CLS_W'(CC_SHIFT);

  ccf_t raw, fin;
  logic bad;
  logic in_fire;
  logic z_hist;

  ccf_formula #(.W(W)) u_formula (
    .cls(in_cls), .res(in_res), .src(in_src), .flags(raw), .bad(bad)
  );

  assign in_ready = !out_valid || out_ready;
  assign in_fire  = in_valid && in_ready;

  // Sticky chain: Z may stay set or drop, never rise.
  always_comb begin
    fin   = raw;
    fin.z = raw.z & (!in_sticky | z_hist);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_flags <= '0;
      err_pulse <= 1'b0;
      z_hist    <= 1'b1;
    end else begin
      err_pulse <= in_fire && bad;
      if (in_fire) begin
        out_valid <= 1'b1;
        out_flags <= bad ? 4'b0000 : fin;
        if (!bad) z_hist <= fin.z;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  a_r1_nz_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && in_cls != '0 && in_cls <= LAST_CLS) |=> !(out_flags[3] && out_flags[2]));

  a_r7_shift_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && in_cls == LAST_CLS) |=> (out_flags[0] == ($past(in_src) != '0)) && !out_flags[1]);

  a_r9_sticky_z: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && in_sticky && !z_hist && in_cls <= LAST_CLS) |=> !out_flags[2]);

  a_r10_bad_class: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && in_cls > LAST_CLS) |=> err_pulse && out_flags == 4'b0000);

  a_r10_no_spurious_err: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_fire && in_cls > LAST_CLS) |=> !err_pulse);

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_flags));

  a_r11_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |=> out_valid);
endmodule

// File: tb/tb_ccf_lazy_eval.sv
module tb_ccf_lazy_eval;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [3:0] in_cls = '0;
  logic [W-1:0] in_res = '0;
  logic [W-1:0] in_src = '0;
  logic in_sticky = 1'b0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [3:0] out_flags;
  logic err_pulse;

  int n_checks = 0;
  int n_fail = 0;
  bit zh = 1'b1;
  bit done = 1'b0;

  ccf_lazy_eval #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_cls(in_cls), .in_res(in_res), .in_src(in_src), .in_sticky(in_sticky),
    .out_valid(out_valid), .out_ready(out_ready), .out_flags(out_flags),
    .err_pulse(err_pulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(int cls);
    case (cls)
      0: return "R8";
      1: return "R7";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R4";
      6: return "R5";
      7: return "R6";
      8: return "R7";
      default: return "R10";
    endcase
  endfunction

  // Returns {err, N, Z, V, C}, built from the requirement text.
  function automatic logic [4:0] model(int cls, logic [31:0] r, logic [31:0] s,
                                       bit st, bit zhist);
    int w;
    longint mask, rr, ss, a, m, sum, diff;
    bit n, z, v, c, sr, sm, sa, sx;
    if (cls > 8) return 5'b10000;
    if (cls == 0) begin
      z = r[2] & (!st | zhist);
      return {1'b0, r[3], z, r[1], r[0]};
    end
    w = (cls == 4) ? 8 : (cls == 5) ? 16 : 32;
    mask = (longint'(1) << w) - 1;
    rr = longint'(r) & mask;
    ss = longint'(s) & mask;
    z = (rr == 0);
    sr = rr[w-1];
    sx = ss[w-1];
    n = !z && sr;
    v = 0;
    c = 0;
    case (cls)
      2, 6: begin
        a = (rr - ss - ((cls == 6) ? 1 : 0)) & mask;
        sa = a[w-1];
        sum = a + ss + ((cls == 6) ? 1 : 0);
        c = sum[w];
        v = (sa == sx) && (sr != sx);
      end
      3, 4, 5, 7: begin
        m = (rr + ss + ((cls == 7) ? 1 : 0)) & mask;
        sm = m[w-1];
        diff = m - ss - ((cls == 7) ? 1 : 0);
        c = diff < 0;
        v = (sm != sx) && (sr != sm);
      end
      8: c = (s != 0);
      default: ;
    endcase
    z = z & (!st | zhist);
    return {1'b0, n, z, v, c};
  endfunction

  task automatic send(int cls, logic [31:0] r, logic [31:0] s, bit st);
    logic [4:0] e;
    @(negedge clk);
    in_valid = 1'b1; in_cls = 4'(cls); in_res = r; in_src = s; in_sticky = st;
    @(negedge clk);
    in_valid = 1'b0;
    e = model(cls, r, s, st, zh);
    chk("R11", 32'(out_valid), 32'd1, "out_valid after accept");
    chk(tag_of(cls), 32'(out_flags), 32'(e[3:0]), $sformatf("flags cls %0d", cls));
    chk("R10", 32'(err_pulse), 32'(e[4]), "err_pulse");
    if (!e[4]) zh = e[2];
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [4:0] e;
    void'($urandom(32'h5EED_0C0F));
    repeat (3) @(negedge clk);
    chk("R12", 32'(out_valid), 32'd0, "reset out_valid");
    chk("R12", 32'(out_flags), 32'd0, "reset flags");
    chk("R12", 32'(err_pulse), 32'd0, "reset err");
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", 32'(in_ready), 32'd1, "ready when empty");

    // R12: first sticky op with zero result still reports Z
    send(1, 32'h0, 32'h0, 1'b1);
    chk("R12", 32'(out_flags), 32'h4, "first sticky zero");
    // R2: signed overflow on add
    send(2, 32'h8000_0000, 32'h7FFF_FFFF, 1'b0);
    chk("R2", 32'(out_flags), 32'hA, "add overflow");
    // R2/R5: result equal to source
    send(2, 32'h1234, 32'h1234, 1'b0);
    send(6, 32'h1234, 32'h1234, 1'b0);
    chk("R5", 32'(out_flags[0]), 32'd1, "addx carry on equal");
    // R3: subtract overflow
    send(3, 32'h7FFF_FFFF, 32'h1, 1'b0);
    chk("R3", 32'(out_flags), 32'h2, "sub overflow");
    send(7, 32'hFFFF_FFFF, 32'h0, 1'b0);
    // R4: upper bits ignored on narrow compares
    send(4, 32'hABCD_EF00, 32'h5A5A_5A80, 1'b0);
    send(5, 32'hFFFF_8000, 32'h1234_0001, 1'b0);
    // R7/R8
    send(8, 32'h0, 32'h0, 1'b0);
    send(8, 32'h8000_0000, 32'h1, 1'b0);
    send(0, 32'hFFFF_FFF5, 32'h0, 1'b0);
    chk("R8", 32'(out_flags), 32'h5, "passthrough bits");

    // R9: sticky chain
    send(2, 32'h0000_0001, 32'h0, 1'b0);
    send(6, 32'h0, 32'h0, 1'b1);
    chk("R9", 32'(out_flags[2]), 32'd0, "sticky keeps Z clear");

    // R10/R11: stall with undefined class, then sticky record behind it
    @(negedge clk);
    out_ready = 1'b0;
    send(12, 32'h0, 32'h0, 1'b0);
    chk("R10", 32'(out_flags), 32'h0, "bad class flags");
    @(negedge clk);
    chk("R10", 32'(err_pulse), 32'd0, "err single cycle under stall");
    in_valid = 1'b1; in_cls = 4'd1; in_res = 32'h0; in_src = 32'h0; in_sticky = 1'b0;
    // zh still reflects last valid op (clear), so a zero result stays unaccepted-check
    @(negedge clk);
    chk("R11", 32'(in_ready), 32'd0, "ready low while stalled");
    chk("R11", 32'(out_flags), 32'h0, "held flags");
    chk("R11", 32'(out_valid), 32'd1, "held valid");
    in_res = 32'h55; in_sticky = 1'b1;
    @(negedge clk);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    e = model(1, 32'h55, 32'h0, 1'b1, zh);
    chk("R11", 32'(out_flags), 32'(e[3:0]), "record taken after release");
    zh = e[2];
    send(1, 32'h0, 32'h0, 1'b1);
    chk("R9", 32'(out_flags[2]), 32'd0, "sticky after stalled nonzero");
    send(1, 32'h0, 32'h0, 1'b0);
    chk("R9", 32'(out_flags[2]), 32'd1, "non-sticky zero sets Z");
    send(1, 32'h0, 32'h0, 1'b1);
    chk("R9", 32'(out_flags[2]), 32'd1, "sticky after zero keeps Z");
    send(9, 32'h1, 32'h0, 1'b0);
    send(1, 32'h0, 32'h0, 1'b1);
    chk("R10", 32'(out_flags[2]), 32'd1, "bad class leaves history");

    // Random mix
    for (int i = 0; i < 400; i++) begin
      int cls;
      logic [31:0] r, s;
      int mode;
      cls = ($urandom % 8 == 0) ? int'($urandom_range(9, 15)) : int'($urandom_range(0, 8));
      mode = int'($urandom % 4);
      r = $urandom;
      s = $urandom;
      if (mode == 0) begin r = $urandom % 4; s = $urandom % 4; end
      else if (mode == 1) s = r;
      else if (mode == 2) r = r & 32'hFFFF_0000;
      send(cls, r, s, bit'($urandom % 2));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule